// File: doc/BRIEF.md
# Retention-Binned Row Refresh Scheduler

This block decides, row by row, which DRAM rows a memory controller must refresh. Instead of refreshing every row at the shortest retention period, rows are grouped into three retention classes: a fast class refreshed every 64 ms, a middle class refreshed every 128 ms, and a slow default class refreshed every 256 ms. Membership in the two shorter classes is held in two Bloom filters. A profiling agent fills them through an insert port before refreshing starts, and a clear input empties them.

A base timer supplies one tick per row slot. On each tick the scheduler looks up the current row in both filters. It raises a refresh request for that row only if the row's class is due in the current 64 ms round, and then moves to the next row. Rounds count modulo 4. While a request waits for its acknowledge the walk holds still, so no row slot is lost. A Bloom false positive places a row in a shorter class than needed. That costs extra refreshes but never loses data.

Top module: `retention_refresh_sched`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) ref_req_o is low, the walk stands at row 0 in round 0, and both filters are empty.
- R2: At a clock edge with tick_i high and no request pending, the current row is evaluated and the walk advances by one row in ascending order. If the row is due, ref_req_o and ref_row_o show it after that edge. After the last row the walk wraps to row 0 and the round advances modulo 4.
- R3: A row found in the fast filter (ins_bin_i = 0, 64 ms class) is requested in every round.
- R4: A row found only in the middle filter (ins_bin_i = 1, 128 ms class) is requested in rounds 0 and 2 only.
- R5: A row found in neither filter (256 ms class) is requested in round 0 only.
- R6: A row found in both filters takes the shorter period and is requested in every round.
- R7: An insert (ins_valid_i high) sets bits h0 and h1 of the selected filter, and a row is a member when both of its bits are set. h0 bit i is the XOR of all row address bits whose index modulo 10 equals i. h1 is h0 bit-reversed, XOR 10'h155.
- R8: clear_i empties both filters at the next edge and wins over an insert in the same cycle.
- R9: While ref_req_o is high and ref_ack_i is low, ref_row_o holds and ticks are ignored. ref_ack_i high for one cycle drops the request at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Row slot pulse from the base timer |
| clear_i | input | 1 | Empty both filters |
| ins_valid_i | input | 1 | Profiling insert strobe |
| ins_bin_i | input | 1 | Target filter: 0 = 64 ms, 1 = 128 ms |
| ins_row_i | input | ROW_W | Row address to insert |
| ref_req_o | output | 1 | Refresh request for ref_row_o |
| ref_row_o | output | ROW_W | Row to refresh |
| ref_ack_i | input | 1 | Request accepted |

## Verification
The walk is run for five consecutive rounds with three filter profiles. With empty filters, only rounds 0 and 4 produce requests, which separates the default class from the others. With rows loaded into the fast filter, the middle filter and both filters, each class's round pattern becomes visible, and the row in both filters shows the shorter period winning. A profile loaded, cleared, and partly reloaded (including an insert coinciding with clear) shows whether clearing works and takes priority. The dual-class profile is replayed with a late acknowledge, so a stalled walk that skipped or replaced a row would break the expected sequence.

// File: rtl/rr_pkg.sv
// Shared definitions for the retention-binned refresh scheduler.
// Assumes the three retention classes are in ratio 1:2:4 of the base round.
package rr_pkg;
    localparam int ROUND_W = 2;   // rounds counted modulo 4 (256/64)

    typedef enum logic [0:0] {BIN_FAST = 1'b0, BIN_MID = 1'b1} bin_e;

    // Decide whether a row is due in a round from its filter membership.
    function automatic logic row_due(input logic [ROUND_W-1:0] round,
                                     input logic in_fast, input logic in_mid);
        if (in_fast)     return 1'b1;
        else if (in_mid) return (round[0] == 1'b0);
        else             return (round == '0);
    endfunction
endpackage

// File: rtl/rr_hash.sv
// Two Bloom hash indices for a row address.
// h0 XOR-folds the address into IDX_W bits; h1 is h0 bit-reversed and salted.
// Purely combinational; assumes ROW_W >= 1.
module rr_hash #(
    parameter int ROW_W = 8,
    parameter int IDX_W = 10,
    parameter logic [IDX_W-1:0] SALT = 10'h155
) (
    input  logic [ROW_W-1:0] row_i,
    output logic [IDX_W-1:0] h0_o,
    output logic [IDX_W-1:0] h1_o
);
    localparam int CHUNKS = (ROW_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W  = CHUNKS * IDX_W;

    logic [PAD_W-1:0] padded;

    // Fold the zero-extended address chunk by chunk.
    always_comb begin
        padded = '0;
        padded[ROW_W-1:0] = row_i;
        h0_o = '0;
        for (int c = 0; c < CHUNKS; c++) begin
            h0_o = h0_o ^ padded[c*IDX_W +: IDX_W];
        end
    end

    // Second index: reverse bit order of the first, then salt.
    always_comb begin
        for (int i = 0; i < IDX_W; i++) begin
            h1_o[i] = h0_o[IDX_W-1-i] ^ SALT[i];
        end
    end
endmodule

// File: rtl/rr_bloom.sv
// One Bloom filter bit vector of 2**IDX_W bits.
// Insert sets two indexed bits; lookup reports a hit when both are set.
// Clear has priority over insert. Assumes indices are already hashed.
module rr_bloom #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             set_i,
    input  logic [IDX_W-1:0] set_h0_i,
    input  logic [IDX_W-1:0] set_h1_i,
    input  logic [IDX_W-1:0] look_h0_i,
    input  logic [IDX_W-1:0] look_h1_i,
    output logic             hit_o
);
    localparam int NBITS = 1 << IDX_W;

    logic [NBITS-1:0] bits_q;

    // Filter storage: reset/clear empty it, insert sets two bits.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            bits_q <= '0;
        end else if (set_i) begin
            bits_q[set_h0_i] <= 1'b1;
            bits_q[set_h1_i] <= 1'b1;
        end
    end

    // Membership lookup.
    always_comb hit_o = bits_q[look_h0_i] & bits_q[look_h1_i];

    // R8: clear leaves the filter empty
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (bits_q == '0));
    // R7: an insert makes both hashed bits set
    a_r7_insert_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clear_i) |=> (bits_q[$past(set_h0_i)] && bits_q[$past(set_h1_i)]));
endmodule

// File: rtl/rr_walker.sv
// Row walk and request stage. Each tick without a pending request evaluates
// the current row against its class and the round, then advances.
// A pending request freezes the walk until acknowledged.
module rr_walker #(
    parameter int ROW_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_i,
    input  logic                       ack_i,
    input  logic                       in_fast_i,
    input  logic                       in_mid_i,
    output logic [ROW_W-1:0]           ptr_o,
    output logic                       req_o,
    output logic [ROW_W-1:0]           row_o
);
    import rr_pkg::*;

    logic [ROUND_W-1:0] round_q;
    logic [ROW_W-1:0]   ptr_q;
    logic               req_q;
    logic [ROW_W-1:0]   row_q;
    logic               step;

    // A row slot is consumed only when no request is outstanding.
    always_comb step = tick_i && !req_q;

    // Walk pointer and round counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            round_q <= '0;
        end else if (step) begin
            ptr_q <= ptr_q + 1'b1;
            if (ptr_q == '1) round_q <= round_q + 1'b1;
        end
    end

    // Request register: set for a due row, dropped on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            row_q <= '0;
        end else if (req_q) begin
            if (ack_i) req_q <= 1'b0;
        end else if (step && row_due(round_q, in_fast_i, in_mid_i)) begin
            req_q <= 1'b1;
            row_q <= ptr_q;
        end
    end

    always_comb begin
        ptr_o = ptr_q;
        req_o = req_q;
        row_o = row_q;
    end

    // R9: an unacknowledged request stays up with the same row
    a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !ack_i) |=> (req_q && $stable(row_q)));
    // R9: walk does not move while a request waits
    a_r9_walk_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> $stable(ptr_q));
    // R2: the round advances when the walk wraps
    a_r2_round_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (step && ptr_q == '1) |=> (round_q == $past(round_q) + 1'b1));
    // R3: a fast-class row always produces a request
    a_r3_fast_requests: assert property (@(posedge clk) disable iff (!rst_n)
        (step && in_fast_i) |=> (req_q && row_q == $past(ptr_q)));
endmodule

// File: rtl/retention_refresh_sched.sv
// Retention-binned refresh scheduler top.
// Two Bloom filters (fast and middle class) are filled by the profiling port;
// the walker issues per-row refresh requests when the row's class is due.
// Assumes profiling completes before ticks start; inserts during the walk
// take effect from the next evaluated row.
module retention_refresh_sched #(
    parameter int ROW_W = 8,
    parameter int IDX_W = 10,
    parameter logic [IDX_W-1:0] SALT = 10'h155
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             clear_i,
    input  logic             ins_valid_i,
    input  logic             ins_bin_i,
    input  logic [ROW_W-1:0] ins_row_i,
    output logic             ref_req_o,
    output logic [ROW_W-1:0] ref_row_o,
    input  logic             ref_ack_i
);
    import rr_pkg::*;

    localparam int NFILT = 2;

    logic [IDX_W-1:0] ins_h0, ins_h1, walk_h0, walk_h1;
    logic [ROW_W-1:0] walk_ptr;
    logic [NFILT-1:0] hit;

    rr_hash #(.ROW_W(ROW_W), .IDX_W(IDX_W), .SALT(SALT)) u_ins_hash (
        .row_i(ins_row_i), .h0_o(ins_h0), .h1_o(ins_h1));

    rr_hash #(.ROW_W(ROW_W), .IDX_W(IDX_W), .SALT(SALT)) u_walk_hash (
        .row_i(walk_ptr), .h0_o(walk_h0), .h1_o(walk_h1));

    for (genvar b = 0; b < NFILT; b++) begin : g_filt
        rr_bloom #(.IDX_W(IDX_W)) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear_i  (clear_i),
            .set_i    (ins_valid_i && (ins_bin_i == b[0])),
            .set_h0_i (ins_h0),
            .set_h1_i (ins_h1),
            .look_h0_i(walk_h0),
            .look_h1_i(walk_h1),
            .hit_o    (hit[b])
        );
    end

    rr_walker #(.ROW_W(ROW_W)) u_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .ack_i    (ref_ack_i),
        .in_fast_i(hit[BIN_FAST]),
        .in_mid_i (hit[BIN_MID]),
        .ptr_o    (walk_ptr),
        .req_o    (ref_req_o),
        .row_o    (ref_row_o)
    );
endmodule

// File: tb/retention_refresh_sched_test.sv
// Scoreboard bench: the driver pushes the expected refresh rows for five
// rounds; the monitor pops and compares each request and acknowledges it.
module retention_refresh_sched_test;
    localparam int ROW_W = 8;
    localparam int IDX_W = 10;
    localparam int ROWS  = 1 << ROW_W;
    localparam int NB    = 1 << IDX_W;
    localparam logic [IDX_W-1:0] SALT = 10'h155;

    logic clk = 0, rst_n = 0, tick = 0, clr = 0, ins_v = 0, ins_b = 0, ack = 0;
    logic [ROW_W-1:0] ins_r = '0;
    logic req;
    logic [ROW_W-1:0] row;

    int vectors = 0, miscompares = 0, ack_wait = 0, wcnt = 0, cycles = 0;
    string tag = "R1";
    int q[$];
    bit model_f [NB];
    bit model_m [NB];

    always #2 clk = ~clk;   // 250 MHz

    retention_refresh_sched #(.ROW_W(ROW_W), .IDX_W(IDX_W), .SALT(SALT)) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .clear_i(clr),
        .ins_valid_i(ins_v), .ins_bin_i(ins_b), .ins_row_i(ins_r),
        .ref_req_o(req), .ref_row_o(row), .ref_ack_i(ack));

    function automatic int hidx(input int r, input bit second);
        logic [IDX_W-1:0] a, b;
        a = '0;
        for (int j = 0; j < ROW_W; j++) a[j % IDX_W] = a[j % IDX_W] ^ r[j];
        for (int i = 0; i < IDX_W; i++) b[i] = a[IDX_W-1-i] ^ SALT[i];
        return second ? int'(b) : int'(a);
    endfunction

    function automatic bit member(input bit fast, input int r);
        if (fast) return model_f[hidx(r,0)] && model_f[hidx(r,1)];
        return model_m[hidx(r,0)] && model_m[hidx(r,1)];
    endfunction

    task automatic check(input bit ok, input string what, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; tick = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
        for (int i = 0; i < NB; i++) begin model_f[i] = 0; model_m[i] = 0; end
    endtask

    task automatic insert(input bit bin, input int r, input bit with_clear);
        @(negedge clk); ins_v = 1; ins_b = bin; ins_r = r[ROW_W-1:0]; clr = with_clear;
        @(negedge clk); ins_v = 0; clr = 0;
        if (with_clear) begin
            for (int i = 0; i < NB; i++) begin model_f[i] = 0; model_m[i] = 0; end
        end else if (bin == 0) begin
            model_f[hidx(r,0)] = 1; model_f[hidx(r,1)] = 1;
        end else begin
            model_m[hidx(r,0)] = 1; model_m[hidx(r,1)] = 1;
        end
    endtask

    // Expected rows for rounds 0..4 from the class rules (R3..R6).
    task automatic run_rounds();
        for (int rd = 0; rd < 5; rd++) begin
            for (int x = 0; x < ROWS; x++) begin
                bit f, m, due;
                f = member(1, x); m = member(0, x);
                if (f) due = 1;
                else if (m) due = ((rd % 4) % 2 == 0);
                else due = ((rd % 4) == 0);
                if (due) q.push_back(x);
            end
        end
        @(negedge clk); tick = 1;
        while (q.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    // Monitor: compare and acknowledge each request.
    initial begin
        forever begin
            @(negedge clk);
            ack = 0;
            if (rst_n && req) begin
                if (q.size() == 0) begin
                    check(0, "unexpected request row", int'(row), -1);
                    ack = 1;
                end else if (wcnt < ack_wait) begin
                    check(int'(row) == q[0], "R9 row held while stalled", int'(row), q[0]);
                    wcnt++;
                end else begin
                    int e;
                    e = q.pop_front();
                    check(int'(row) == e, "refresh row", int'(row), e);
                    ack = 1; wcnt = 0;
                    if (q.size() == 0) tick = 0;
                end
            end
        end
    end

    // Watchdog.
    initial begin
        forever begin
            @(posedge clk); cycles++;
            if (cycles > 150000) begin
                check(0, "watchdog expired", cycles, 150000);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
                $finish;
            end
        end
    end

    initial begin
        // R1: reset state; a tick right after reset must request row 0 (round 0)
        tag = "R1";
        do_reset();
        check(req == 0, "R1 no request after reset", int'(req), 0);
        // R1/R5: empty filters, so only rounds 0 and 4 request (every row)
        tag = "R1/R2/R5";
        run_rounds();
        // R3/R4/R6/R7: mixed profile
        tag = "R3/R4/R6/R7";
        do_reset();
        insert(0, 3, 0); insert(0, 77, 0);
        insert(1, 10, 0); insert(1, 200, 0);
        insert(0, 50, 0); insert(1, 50, 0);
        run_rounds();
        // R8: clear wins over a simultaneous insert; later insert still works
        tag = "R8";
        do_reset();
        insert(0, 3, 0); insert(1, 120, 0);
        insert(0, 9, 1);
        insert(1, 33, 0);
        run_rounds();
        // R9: late acknowledge stalls the walk without losing a row
        tag = "R9";
        do_reset();
        ack_wait = 3;
        insert(0, 5, 0); insert(1, 6, 0); insert(0, 250, 0);
        run_rounds();
        ack_wait = 0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule